// File: doc/BRIEF.md
# USB3 Root Port Status and Control Register

This block holds the 32-bit status and control word for one USB3 root-hub port. Software reaches it with full dword writes and reads over a simple register bus. The word sits at byte offset 0x480 + NUM_USB2*0x10 + PORT_IDX*0x10. On the other side, the port logic feeds the block with level inputs and pulse events. The levels are connected, cold-attach, over-current, enabled and speed. The pulses are link-state change, hot/warm reset done and configuration error. In return the block issues hot and warm reset requests, strobe-qualified link-state requests, disable requests and the port power enable.

A small reset sequencer drives both reset requests. It has three states. RST_IDLE moves to RST_WARM when a write sets the warm bit; the warm bit takes precedence if both are set. RST_IDLE moves to RST_HOT when a write sets only the reset bit. RST_HOT returns to RST_IDLE on the hot-done event. RST_WARM returns to RST_IDLE on the warm-done event. Return edges are named hot_finish and warm_finish. Every other condition keeps the current state. Seven sticky change flags collect events. Software clears them by writing 1.

Top module: `usb3_port_status`

## Requirements
- R1: After reset the word reads 0x000002A0: power (bit 9) is 1, link state (bits 8..5) is 5, every other bit is 0 while the level inputs are low.
- R2: Writing 1 to bit 4 enters RST_HOT. Bit 4 and hot_reset_req stay 1 until hot_reset_done, then return to 0, and the reset-change flag (bit 21) becomes 1. Reset-bit writes during a reset are ignored.
- R3: Writing 1 to bit 31 enters RST_WARM. Bit 31 and warm_reset_req stay 1 until warm_reset_done, after which the warm-change flag (bit 19) becomes 1.
- R4: The connect-change flag (bit 17) is set on any change of port_connected (read at bit 0) or of port_cold_attach (read at bit 24).
- R5: Bits 8..5 take write data only when bit 16 of the same write is 1. Such a write pulses link_req for one cycle with link_req_state equal to the written value. Bit 16 always reads 0.
- R6: Writing 1 to any of bits 23..17 clears that flag; writing 0 leaves it unchanged.
- R7: Bit 1 mirrors port_enabled. Writing 1 to bit 1 pulses port_disable_req for one cycle and does not set bit 1. Every change of port_enabled sets flag bit 18.
- R8: Reserved bits 29..28 and 2 read 0. Speed (bits 13..10), cold attach, over-current active and connected ignore writes.
- R9: A flag-setting event in the same cycle as a write-1-to-clear of that flag leaves the flag set.
- R10: Writes to any other address change nothing, and reads at other addresses return 0.
- R11: Bit 3 mirrors port_overcurrent, and a change of it sets bit 20. cfg_err_evt sets bit 23. link_chg_evt loads link_chg_state into bits 8..5 and sets bit 22; it wins over a strobed write in the same cycle.
- R12: Bits 30, 27..25, 15..14 and 9 hold written values; port_power follows bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of access |
| bus_wr_en | input | 1 | Dword write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, 0 when address misses |
| port_connected | input | 1 | Current connect level |
| port_cold_attach | input | 1 | Cold attach level |
| port_overcurrent | input | 1 | Over-current level |
| port_enabled | input | 1 | Port enabled level from port logic |
| port_speed | input | 4 | Speed code of attached device |
| link_chg_evt | input | 1 | Link state changed (pulse) |
| link_chg_state | input | 4 | New link state with link_chg_evt |
| hot_reset_done | input | 1 | Hot reset completed (pulse) |
| warm_reset_done | input | 1 | Warm reset completed (pulse) |
| cfg_err_evt | input | 1 | Configuration error (pulse) |
| hot_reset_req | output | 1 | Hot reset in progress request |
| warm_reset_req | output | 1 | Warm reset in progress request |
| link_req | output | 1 | One-cycle link-state change request |
| link_req_state | output | 4 | Requested link state |
| port_disable_req | output | 1 | One-cycle disable request |
| port_power | output | 1 | Port power enable |

## Verification
Two pairs of functions can land in the same cycle here. The first is a software clear of a change flag together with the hardware event that sets that flag. The second is a strobed link-state write together with a hardware link-state change. The bench drives the configuration-error pulse in the same cycle as a write of 1 to bit 23. It expects the flag to stay set, and a later lone clear to remove it. It also drives a strobed write and link_chg_evt together. It expects the hardware value in bits 8..5, while link_req still pulses with the written value.

// File: rtl/usb3ps_pkg.sv
package usb3ps_pkg;
    typedef enum logic [1:0] {
        RST_IDLE = 2'd0,
        RST_HOT  = 2'd1,
        RST_WARM = 2'd2
    } rst_state_e;

    localparam int WORD_W    = 32;
    localparam int LS_W      = 4;
    localparam int SPD_W     = 4;
    localparam int N_CHG     = 7;

    localparam int B_WARM    = 31;
    localparam int B_REMOV   = 30;
    localparam int B_WAKE_LO = 25;
    localparam int B_COLD    = 24;
    localparam int B_CHG_LO  = 17;
    localparam int B_STROBE  = 16;
    localparam int B_IND_LO  = 14;
    localparam int B_SPD_LO  = 10;
    localparam int B_PWR     = 9;
    localparam int B_LS_LO   = 5;
    localparam int B_HOT     = 4;
    localparam int B_OVC     = 3;
    localparam int B_ENA     = 1;
    localparam int B_CONN    = 0;

    localparam int C_CONN  = 0;
    localparam int C_ENA   = 1;
    localparam int C_WARM  = 2;
    localparam int C_OVC   = 3;
    localparam int C_HOT   = 4;
    localparam int C_LINK  = 5;
    localparam int C_CFG   = 6;

    localparam logic [LS_W-1:0] LS_RESET = 4'd5;
endpackage

// File: rtl/usb3ps_reset_fsm.sv
module usb3ps_reset_fsm
    import usb3ps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_hot,
    input  logic start_warm,
    input  logic hot_done,
    input  logic warm_done,
    output logic hot_active,
    output logic warm_active,
    output logic hot_finish,
    output logic warm_finish
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE: begin
                if (start_warm)     state_d = RST_WARM;
                else if (start_hot) state_d = RST_HOT;
            end
            RST_HOT:  if (hot_done)  state_d = RST_IDLE;
            RST_WARM: if (warm_done) state_d = RST_IDLE;
            default:  state_d = RST_IDLE;
        endcase
    end

    always_comb begin
        hot_active  = 1'b0;
        warm_active = 1'b0;
        hot_finish  = 1'b0;
        warm_finish = 1'b0;
        unique case (state_q)
            RST_IDLE: ;
            RST_HOT: begin
                hot_active = 1'b1;
                hot_finish = hot_done;
            end
            RST_WARM: begin
                warm_active = 1'b1;
                warm_finish = warm_done;
            end
            default: ;
        endcase
    end

    // R2
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_active && !hot_done) |=> hot_active);
    // R3
    warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_active && !warm_done) |=> warm_active);
    // R2
    one_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hot_active && warm_active));
endmodule

// File: rtl/usb3ps_change_flags.sv
module usb3ps_change_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_o[i] <= 1'b0;
            else if (set_i[i]) flags_o[i] <= 1'b1;
            else if (clr_i[i]) flags_o[i] <= 1'b0;
        end
    end

    // R6
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/usb3ps_link_state.sv
module usb3ps_link_state #(
    parameter int          W         = 4,
    parameter logic [W-1:0] RESET_VAL = 4'd5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_val,
    input  logic         hw_chg,
    input  logic [W-1:0] hw_val,
    output logic [W-1:0] state_o,
    output logic         req_o,
    output logic [W-1:0] req_state_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_o     <= RESET_VAL;
            req_o       <= 1'b0;
            req_state_o <= '0;
        end else begin
            if (hw_chg)     state_o <= hw_val;
            else if (sw_wr) state_o <= sw_val;
            req_o <= sw_wr;
            if (sw_wr) req_state_o <= sw_val;
        end
    end

    // R5
    ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !hw_chg) |=> $stable(state_o));
    // R11
    ls_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_chg |=> (state_o == $past(hw_val)));
endmodule

// File: rtl/usb3_port_status.sv
module usb3_port_status
    import usb3ps_pkg::*;
#(
    parameter int NUM_USB2 = 16,
    parameter int PORT_IDX = 0,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    output logic [31:0]       bus_rd_data,
    input  logic              port_connected,
    input  logic              port_cold_attach,
    input  logic              port_overcurrent,
    input  logic              port_enabled,
    input  logic [3:0]        port_speed,
    input  logic              link_chg_evt,
    input  logic [3:0]        link_chg_state,
    input  logic              hot_reset_done,
    input  logic              warm_reset_done,
    input  logic              cfg_err_evt,
    output logic              hot_reset_req,
    output logic              warm_reset_req,
    output logic              link_req,
    output logic [3:0]        link_req_state,
    output logic              port_disable_req,
    output logic              port_power
);
    localparam int                REG_OFF_I = 'h480 + NUM_USB2 * 'h10 + PORT_IDX * 'h10;
    localparam logic [ADDR_W-1:0] REG_OFF   = REG_OFF_I[ADDR_W-1:0];

    logic              sel, wr_hit;
    logic              conn_q, cold_q, ovc_q, ena_q;
    logic              removable_q, power_q;
    logic [2:0]        wake_q;
    logic [1:0]        ind_q;
    logic              disable_q;
    logic [N_CHG-1:0]  chg_set, chg_clr, chg_flags;
    logic [LS_W-1:0]   ls_cur;
    logic              hot_fin, warm_fin;

    assign sel    = (bus_addr == REG_OFF);
    assign wr_hit = sel && bus_wr_en;

    usb3ps_reset_fsm u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hot  (wr_hit && bus_wr_data[B_HOT]),
        .start_warm (wr_hit && bus_wr_data[B_WARM]),
        .hot_done   (hot_reset_done),
        .warm_done  (warm_reset_done),
        .hot_active (hot_reset_req),
        .warm_active(warm_reset_req),
        .hot_finish (hot_fin),
        .warm_finish(warm_fin)
    );

    usb3ps_link_state #(.W(LS_W), .RESET_VAL(LS_RESET)) u_ls (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (wr_hit && bus_wr_data[B_STROBE]),
        .sw_val     (bus_wr_data[B_LS_LO +: LS_W]),
        .hw_chg     (link_chg_evt),
        .hw_val     (link_chg_state),
        .state_o    (ls_cur),
        .req_o      (link_req),
        .req_state_o(link_req_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            cold_q <= 1'b0;
            ovc_q  <= 1'b0;
            ena_q  <= 1'b0;
        end else begin
            conn_q <= port_connected;
            cold_q <= port_cold_attach;
            ovc_q  <= port_overcurrent;
            ena_q  <= port_enabled;
        end
    end

    always_comb begin
        chg_set         = '0;
        chg_set[C_CONN] = (conn_q != port_connected) || (cold_q != port_cold_attach);
        chg_set[C_ENA]  = (ena_q != port_enabled);
        chg_set[C_WARM] = warm_fin;
        chg_set[C_OVC]  = (ovc_q != port_overcurrent);
        chg_set[C_HOT]  = hot_fin;
        chg_set[C_LINK] = link_chg_evt;
        chg_set[C_CFG]  = cfg_err_evt;
        chg_clr         = wr_hit ? bus_wr_data[B_CHG_LO +: N_CHG] : '0;
    end

    usb3ps_change_flags #(.N(N_CHG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (chg_set),
        .clr_i  (chg_clr),
        .flags_o(chg_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            removable_q <= 1'b0;
            wake_q      <= '0;
            ind_q       <= '0;
            power_q     <= 1'b1;
            disable_q   <= 1'b0;
        end else begin
            disable_q <= wr_hit && bus_wr_data[B_ENA];
            if (wr_hit) begin
                removable_q <= bus_wr_data[B_REMOV];
                wake_q      <= bus_wr_data[B_WAKE_LO +: 3];
                ind_q       <= bus_wr_data[B_IND_LO +: 2];
                power_q     <= bus_wr_data[B_PWR];
            end
        end
    end

    assign port_disable_req = disable_q;
    assign port_power       = power_q;

    always_comb begin
        bus_rd_data = '0;
        if (sel) begin
            bus_rd_data[B_WARM]               = warm_reset_req;
            bus_rd_data[B_REMOV]              = removable_q;
            bus_rd_data[B_WAKE_LO +: 3]       = wake_q;
            bus_rd_data[B_COLD]               = port_cold_attach;
            bus_rd_data[B_CHG_LO +: N_CHG]    = chg_flags;
            bus_rd_data[B_IND_LO +: 2]        = ind_q;
            bus_rd_data[B_SPD_LO +: SPD_W]    = port_speed;
            bus_rd_data[B_PWR]                = power_q;
            bus_rd_data[B_LS_LO +: LS_W]      = ls_cur;
            bus_rd_data[B_HOT]                = hot_reset_req;
            bus_rd_data[B_OVC]                = port_overcurrent;
            bus_rd_data[B_ENA]                = port_enabled;
            bus_rd_data[B_CONN]               = port_connected;
        end
    end

    // R2
    prc_on_hot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hot_reset_req) |-> chg_flags[C_HOT]);
    // R3
    wrc_on_warm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_reset_req) |-> chg_flags[C_WARM]);
    // R7
    pec_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_enabled != ena_q) |=> chg_flags[C_ENA]);
    // R10
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (bus_rd_data == '0));
endmodule

// File: tb/usb3_port_status_bench.sv
module usb3_port_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] REG  = 16'h0580;
    localparam logic [31:0] RWM  = 32'h4E00C200;
    localparam logic [31:0] PW   = 32'h0000_0200;

    logic        clk = 0, rst_n = 0;
    logic [15:0] bus_addr = REG;
    logic        bus_wr_en = 0;
    logic [31:0] bus_wr_data = 0;
    logic [31:0] bus_rd_data;
    logic        port_connected = 0, port_cold_attach = 0, port_overcurrent = 0, port_enabled = 0;
    logic [3:0]  port_speed = 0;
    logic        link_chg_evt = 0;
    logic [3:0]  link_chg_state = 0;
    logic        hot_reset_done = 0, warm_reset_done = 0, cfg_err_evt = 0;
    logic        hot_reset_req, warm_reset_req, link_req, port_disable_req, port_power;
    logic [3:0]  link_req_state;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] m_rw;
    logic [3:0]  m_ls;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb3_port_status u_usb3_port_status (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0; bus_addr = REG;
        #1;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    function automatic logic [31:0] model_rd(input logic [31:0] rw, input logic [3:0] ls);
        return (rw & RWM) | (32'(ls) << 5);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset image
        chk("R1 reset", bus_rd_data, 32'h0000_02A0);
        chk("R1 power", {31'd0, port_power}, 32'd1);

        // R2 hot reset
        wr(REG, PW | 32'h10);
        chk("R2 hot req", {31'd0, hot_reset_req}, 1);
        chk("R2 bit4", bus_rd_data & 32'h10, 32'h10);
        repeat (3) step();
        chk("R2 held", {31'd0, hot_reset_req}, 1);
        @(negedge clk); hot_reset_done = 1;
        @(negedge clk); hot_reset_done = 0; #1;
        chk("R2 done", bus_rd_data, 32'h0020_02A0);
        chk("R2 req low", {31'd0, hot_reset_req}, 0);
        wr(REG, PW | 32'h0020_0000);
        chk("R6 clear prc", bus_rd_data, 32'h0000_02A0);

        // R3 warm reset
        wr(REG, PW | 32'h8000_0010);
        chk("R3 warm req", {30'd0, warm_reset_req, hot_reset_req}, 32'd2);
        chk("R3 bit31", bus_rd_data, 32'h8000_02A0);
        @(negedge clk); warm_reset_done = 1;
        @(negedge clk); warm_reset_done = 0; #1;
        chk("R3 done", bus_rd_data, 32'h0008_02A0);
        wr(REG, PW);
        chk("R6 zero write keeps", bus_rd_data, 32'h0008_02A0);
        wr(REG, PW | 32'h0008_0000);
        chk("R6 clear wrc", bus_rd_data, 32'h0000_02A0);

        // R4 connect and cold attach
        @(negedge clk); port_connected = 1; #1;
        chk("R4 ccs", bus_rd_data, 32'h0000_02A1);
        step();
        chk("R4 csc", bus_rd_data, 32'h0002_02A1);
        wr(REG, PW | 32'h0002_0000);
        @(negedge clk); port_cold_attach = 1; step();
        chk("R4 cold csc", bus_rd_data, 32'h0102_02A1);
        @(negedge clk); port_connected = 0; port_cold_attach = 0;
        wr(REG, PW | 32'h0002_0000);
        chk("R4 cleared", bus_rd_data, 32'h0000_02A0);

        // R5 link write strobe
        wr(REG, PW | 32'h0001_0000 | (32'd3 << 5));
        chk("R5 link req", {27'd0, link_req, link_req_state}, {27'd0, 1'b1, 4'd3});
        chk("R5 ls written", bus_rd_data, 32'h0000_0260);
        step();
        chk("R5 req pulse", {31'd0, link_req}, 0);
        wr(REG, PW | (32'd7 << 5));
        chk("R5 no strobe", bus_rd_data, 32'h0000_0260);
        chk("R5 no req", {31'd0, link_req}, 0);

        // R11 link hw + same-cycle strobe
        @(negedge clk);
        bus_wr_en = 1; bus_wr_data = PW | 32'h0001_0000 | (32'd2 << 5);
        link_chg_evt = 1; link_chg_state = 4'd9;
        @(negedge clk); bus_wr_en = 0; link_chg_evt = 0; #1;
        chk("R11 hw link wins", bus_rd_data, 32'h0040_0320);
        chk("R5 req with sw val", {27'd0, link_req, link_req_state}, {27'd0, 1'b1, 4'd2});
        wr(REG, PW | 32'h0041_0000 | (32'd5 << 5));
        chk("R11 plc clear", bus_rd_data, 32'h0000_02A0);

        // R11 over-current and config error
        @(negedge clk); port_overcurrent = 1; step();
        chk("R11 oca occ", bus_rd_data, 32'h0010_02A8);
        @(negedge clk); port_overcurrent = 0; cfg_err_evt = 1;
        @(negedge clk); cfg_err_evt = 0; #1;
        chk("R11 cec", bus_rd_data, 32'h0090_02A0);

        // R9 event beats clear
        @(negedge clk);
        bus_wr_en = 1; bus_wr_data = PW | 32'h0080_0000; cfg_err_evt = 1;
        @(negedge clk); bus_wr_en = 0; cfg_err_evt = 0; #1;
        chk("R9 set wins", bus_rd_data & 32'h0080_0000, 32'h0080_0000);
        wr(REG, PW | 32'h00FE_0000);
        chk("R9 later clear", bus_rd_data, 32'h0000_02A0);

        // R7 enable bit
        wr(REG, PW | 32'h2);
        chk("R7 disable req", {31'd0, port_disable_req}, 1);
        chk("R7 not set", bus_rd_data, 32'h0000_02A0);
        step();
        chk("R7 pulse", {31'd0, port_disable_req}, 0);
        @(negedge clk); port_enabled = 1; step();
        chk("R7 ped pec", bus_rd_data, 32'h0004_02A2);
        @(negedge clk); port_enabled = 0;
        wr(REG, PW | 32'h0004_0000);
        chk("R7 cleared", bus_rd_data, 32'h0000_02A0);

        // R8 reserved and read-only
        @(negedge clk); port_speed = 4'h4;
        wr(REG, 32'h3100_3C0D & ~32'h0000_0012 | PW);
        chk("R8 ro ignored", bus_rd_data, 32'h0000_12A0);
        @(negedge clk); port_speed = 0;

        // R10 other address
        wr(REG + 16'h10, 32'hFFFF_FFFF);
        chk("R10 no change", bus_rd_data, 32'h0000_02A0);
        chk("R10 no req", {30'd0, hot_reset_req, warm_reset_req}, 0);
        @(negedge clk); bus_addr = REG - 16'h10; #1;
        chk("R10 miss read", bus_rd_data, 0);
        bus_addr = REG;

        // R12 random RW fields
        m_rw = PW; m_ls = 4'd5;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] d;
            logic        miss;
            d = $urandom & ~32'h8000_0012;
            miss = ($urandom % 4) == 0;
            wr(miss ? REG + 16'h20 : REG, d);
            if (!miss) begin
                m_rw = d & RWM;
                if (d[16]) m_ls = d[8:5];
            end
            chk(miss ? "R10 random miss" : "R12 random rw", bus_rd_data, model_rd(m_rw, m_ls));
            chk("R12 power pin", {31'd0, port_power}, {31'd0, m_rw[9]});
        end
        finish_run();
    end
endmodule